// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 16-bit peripheral bus and the data path of a UART. It decodes single-cycle bus requests into twelve word-aligned registers. It keeps the baud divisor, control and scratch storage and the interrupt-enable mask. It also keeps sticky line and modem status bits that software clears by writing ones. Writing the transmit holding register hands the low byte to the transmitter as a one-cycle strobe. Reading the receive buffer pops a byte from a ready/valid source.

Every access is answered in the cycle after the request. Read data and an error flag are registered together. Only half-word accesses to one of the twelve offsets take effect. Any other access returns zero and raises the error flag, and no state changes. The interrupt mask cannot be written directly: one alias ORs bits in and a second alias clears the bits written as one. The line-status read merges the stored sticky flags with live receiver and transmitter state.

Top module: `uart_regfile`

## Requirements
- R1: After reset, DLL reads 0x0001 and LSR reads 0x0060 while both transmitter-empty inputs are high and no byte waits. Every other register reads 0x0000.
- R2: Registers sit at byte offsets DLL 0x00, DLH 0x04, GCTL 0x08, LCR 0x0C, MCR 0x10, LSR 0x14, MSR 0x18, SCR 0x1C, IER_SET 0x20, IER_CLEAR 0x24, THR 0x28, RBR 0x2C. DLL, DLH, GCTL, LCR, MCR and SCR store and return all 16 written bits.
- R3: An access with `bus_size` other than 1 (1 = 16-bit) is an error, whatever the address.
- R4: An access to an offset that is misaligned or above 0x2C is an error. An error raises `bus_err` for one cycle, returns 0 on `bus_rdata`, gives no transmit strobe and changes no register.
- R5: A write to IER_SET ORs the data into the mask. A write to IER_CLEAR clears every mask bit written as one. Reading either alias returns the mask, whose bit 1 is the transmit interrupt enable.
- R6: LSR bits OE(1), PE(2), FE(3), BI(4) and TFI(7) are set by the matching `line_evt` bits and cleared by writing one. A set in the same cycle as a clear wins. Writes have no effect on the other LSR bits, and `line_evt` bits 0, 5 and 6 have no effect.
- R7: MSR bit 0 is set by `cts_delta` and cleared only by a write with data bit 0 at one. The other MSR bits read zero.
- R8: A write to THR stores the value. The cycle after the request, it drives `tx_data` with the low byte and raises `tx_valid` for one cycle. In that same cycle `tx_irq` pulses if mask bit 1 is set.
- R9: A read of RBR asserts `rx_ready` combinationally in the request cycle. If `rx_valid` is high, it returns and stores `rx_data`. Otherwise it returns the last stored byte. Writes to RBR have no effect.
- R10: A read of LSR returns bit 0 = `rx_valid`, bit 5 = `tx_hold_empty` and bit 6 = `tx_shift_empty`, sampled in the request cycle, together with the sticky bits.
- R11: `bus_rdata` carries read data in the cycle after a valid read and is 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset from the block base |
| bus_size | input | 2 | Access size code, 1 = 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| bus_err | output | 1 | Invalid access flag, one cycle after the request |
| tx_hold_empty | input | 1 | Live transmitter holding-empty status |
| tx_shift_empty | input | 1 | Live transmitter fully idle status |
| tx_data | output | 8 | Byte for the transmitter |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Pop of the received byte |
| line_evt | input | 8 | Sets the sticky LSR flags at their bit positions |
| cts_delta | input | 1 | Sets the modem-status change flag |

## Verification
The decoder is swept over every 6-bit offset with every size code. This separates the size check from the offset check, and both from a valid hit, including offsets just past the last register and misaligned ones. The storage registers get all-ones, all-zero and two mixed patterns, varied per register, so that any crossed write enable or shared storage shows up. The status registers are driven with events alone, clears alone, and events and clears in the same cycle. All eight combinations of the live line inputs are applied, so that a stale or swapped live bit is told apart from a sticky one. Transmit writes are made with the enable both off and on. Receive reads are made with and without a waiting byte.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_err,
  input  logic          tx_hold_empty,
  input  logic          tx_shift_empty,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_irq,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    line_evt,
  input  logic          cts_delta
);
  localparam int NREG = 12;
  localparam int IW   = AW - 2;
  localparam int I_DLL = 0, I_DLH = 1, I_GCTL = 2, I_LCR = 3, I_MCR = 4, I_LSR = 5;
  localparam int I_MSR = 6, I_SCR = 7, I_ISET = 8, I_ICLR = 9, I_THR = 10, I_RBR = 11;
  localparam logic [15:0] STICKY = 16'h009E;
  localparam logic [AW-1:0] A_ISET = AW'(4 * I_ISET);
  localparam logic [AW-1:0] A_ICLR = AW'(4 * I_ICLR);

  logic [15:0] dll, dlh, gctl, lcr, mcr, scr, lsr, msr, ier, thr, rbr;
  logic [15:0] rd_mux, lsr_live;

  wire [IW-1:0] idx  = bus_addr[AW-1:2];
  wire          hit  = (bus_addr[1:0] == 2'b00) && (idx < IW'(NREG));
  wire          ok   = bus_req && (bus_size == 2'd1) && hit;
  wire          wr   = ok && bus_we;
  wire          rd   = ok && !bus_we;

  function automatic logic at(input logic [IW-1:0] i, input int n);
    return i == IW'(n);
  endfunction

  assign lsr_live = {lsr[15:7], tx_shift_empty, tx_hold_empty, lsr[4:1], rx_valid};
  assign rx_ready = rd && at(idx, I_RBR);

  always_comb begin
    case (int'(idx))
      I_DLL:          rd_mux = dll;
      I_DLH:          rd_mux = dlh;
      I_GCTL:         rd_mux = gctl;
      I_LCR:          rd_mux = lcr;
      I_MCR:          rd_mux = mcr;
      I_LSR:          rd_mux = lsr_live;
      I_MSR:          rd_mux = msr;
      I_SCR:          rd_mux = scr;
      I_ISET, I_ICLR: rd_mux = ier;
      I_THR:          rd_mux = thr;
      I_RBR:          rd_mux = rx_valid ? {8'h00, rx_data} : rbr;
      default:        rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll <= 16'h0001; dlh <= '0; gctl <= '0; lcr <= '0; mcr <= '0; scr <= '0;
      lsr <= 16'h0060; msr <= '0; ier <= '0; thr <= '0; rbr <= '0;
      bus_rdata <= '0; bus_err <= 1'b0;
      tx_data <= '0; tx_valid <= 1'b0; tx_irq <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_mux : 16'h0000;
      bus_err   <= bus_req && !ok;
      tx_valid  <= wr && at(idx, I_THR);
      tx_irq    <= wr && at(idx, I_THR) && ier[1];
      if (wr) begin
        if (at(idx, I_DLL))  dll  <= bus_wdata;
        if (at(idx, I_DLH))  dlh  <= bus_wdata;
        if (at(idx, I_GCTL)) gctl <= bus_wdata;
        if (at(idx, I_LCR))  lcr  <= bus_wdata;
        if (at(idx, I_MCR))  mcr  <= bus_wdata;
        if (at(idx, I_SCR))  scr  <= bus_wdata;
        if (at(idx, I_ISET)) ier  <= ier | bus_wdata;
        if (at(idx, I_ICLR)) ier  <= ier & ~bus_wdata;
        if (at(idx, I_THR)) begin
          thr     <= bus_wdata;
          tx_data <= bus_wdata[7:0];
        end
      end
      if (wr && at(idx, I_LSR))
        lsr <= (lsr & ~(bus_wdata & STICKY)) | ({8'h00, line_evt} & STICKY);
      else if (rd && at(idx, I_LSR))
        lsr <= lsr_live | ({8'h00, line_evt} & STICKY);
      else
        lsr <= lsr | ({8'h00, line_evt} & STICKY);
      msr[0] <= cts_delta || (msr[0] && !(wr && at(idx, I_MSR) && bus_wdata[0]));
      msr[15:1] <= '0;
      if (rx_ready && rx_valid) rbr <= {8'h00, rx_data};
    end
  end

  AST_IRQ_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_valid); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 16'h0000 && !tx_valid)); // R4
  AST_READY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_req && !bus_we && bus_size == 2'd1)); // R9
  AST_IER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_size == 2'd1 && bus_addr == A_ISET)
      |=> ((ier & $past(bus_wdata)) == $past(bus_wdata))); // R5
  AST_IER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_size == 2'd1 && bus_addr == A_ICLR)
      |=> ((ier & $past(bus_wdata)) == 16'h0000)); // R5
  AST_RBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && rx_valid) |=> $stable(rbr)); // R9
  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size != 2'd1) |=> bus_err); // R3
endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  localparam int CLK_NS = 10;
  logic clk = 1'b0, rst_n = 1'b0, bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic tx_hold_empty = 1'b1, tx_shift_empty = 1'b1, rx_valid = 1'b0, cts_delta = 1'b0;
  logic [7:0] rx_data = '0, line_evt = '0;
  logic [15:0] bus_rdata;
  logic bus_err, tx_valid, tx_irq, rx_ready;
  logic [7:0] tx_data;

  uart_regfile #(.AW(6)) uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [15:0] m [12];
  logic [15:0] mier = '0, msticky = '0;
  logic [15:0] r_data;
  logic r_err, r_txv, r_irq, r_rdy;
  logic [7:0] r_txd;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [5:0] a, input logic [1:0] sz, input logic [15:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1 r_rdy = rx_ready;
    @(negedge clk);
    r_data = bus_rdata; r_err = bus_err; r_txv = tx_valid; r_irq = tx_irq; r_txd = tx_data;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [15:0] expect_of(input int i);
    case (i)
      5:    return (msticky & 16'h009E) | {9'h0, tx_shift_empty, tx_hold_empty, 4'h0, rx_valid};
      8, 9: return mier;
      11:   return rx_valid ? {8'h00, rx_data} : m[11];
      default: return m[i];
    endcase
  endfunction

  task automatic rd_chk(input int i, input string tag);
    acc(1'b0, 6'(i * 4), 2'd1, 16'h0);
    chk(tag, r_data, expect_of(i));
    chk({tag, " err"}, {15'h0, r_err}, 16'h0);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 12; i++) rd_chk(i, tag);
  endtask

  task automatic wr(input int i, input logic [15:0] wd);
    acc(1'b1, 6'(i * 4), 2'd1, wd);
    chk("R11 rdata after write", r_data, 16'h0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] pats [4];
    int plain [6];
    pats = '{16'hFFFF, 16'hA5C3, 16'h0000, 16'h1248};
    plain = '{0, 1, 2, 3, 4, 7};
    for (int i = 0; i < 12; i++) m[i] = '0;
    m[0] = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_all("R1 reset");
    chk("R1 tx_valid idle", {15'h0, tx_valid}, 16'h0);

    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 6; k++) begin
        m[plain[k]] = pats[p] ^ (16'h0101 * 16'(k));
        wr(plain[k], m[plain[k]]);
      end
      rd_all("R2 storage");
    end

    begin
      logic [15:0] sv [5];
      logic       isset [5];
      sv = '{16'h0003, 16'h0001, 16'hF0F0, 16'hFFFF, 16'h8002};
      isset = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      for (int s = 0; s < 5; s++) begin
        if (isset[s]) begin mier = mier | sv[s]; wr(8, sv[s]); end
        else begin mier = mier & ~sv[s]; wr(9, sv[s]); end
        rd_chk(8, "R5 set alias");
        rd_chk(9, "R5 clear alias");
      end
    end

    line_evt = 8'h61;
    @(posedge clk); #1 line_evt = 8'h00;
    for (int c = 0; c < 8; c++) begin
      {rx_valid, tx_hold_empty, tx_shift_empty} = 3'(c);
      rd_chk(5, "R10 live bits");
    end
    rx_valid = 1'b0; tx_hold_empty = 1'b1; tx_shift_empty = 1'b1;
    line_evt = 8'hFF;
    @(posedge clk); #1 line_evt = 8'h00;
    msticky = 16'h009E;
    rd_chk(5, "R6 events set");
    wr(5, 16'h0006); msticky = msticky & ~16'h0006;
    rd_chk(5, "R6 clear OE PE");
    wr(5, 16'hFF61);
    rd_chk(5, "R6 non-sticky write ignored");
    wr(5, 16'h0090); msticky = msticky & ~16'h0090;
    rd_chk(5, "R6 clear TFI BI");
    line_evt = 8'h08;
    acc(1'b1, 6'h14, 2'd1, 16'h0008);
    line_evt = 8'h00;
    rd_chk(5, "R6 set wins over clear");
    wr(5, 16'hFFFF); msticky = '0;
    rd_chk(5, "R6 clear all");

    cts_delta = 1'b1;
    @(posedge clk); #1 cts_delta = 1'b0;
    m[6] = 16'h0001;
    rd_chk(6, "R7 delta set");
    wr(6, 16'hFFFE);
    rd_chk(6, "R7 other bits ignored");
    wr(6, 16'h0001); m[6] = '0;
    rd_chk(6, "R7 cleared");

    wr(9, 16'hFFFF); mier = '0;
    for (int ie = 0; ie < 2; ie++) begin
      if (ie == 1) begin wr(8, 16'h0002); mier = 16'h0002; end
      for (int b = 0; b < 3; b++) begin
        logic [7:0] byt;
        byt = (b == 0) ? 8'h00 : (b == 1) ? 8'h5A : 8'hFF;
        m[10] = {8'hC3, byt};
        acc(1'b1, 6'h28, 2'd1, m[10]);
        chk("R8 tx_valid", {15'h0, r_txv}, 16'h1);
        chk("R8 tx_data", {8'h0, r_txd}, {8'h0, byt});
        chk("R8 tx_irq", {15'h0, r_irq}, 16'(ie));
        rd_chk(10, "R8 THR readback");
        chk("R8 strobe one cycle", {15'h0, r_txv}, 16'h0);
      end
    end

    rx_data = 8'h3C; rx_valid = 1'b1;
    acc(1'b0, 6'h2C, 2'd1, 16'h0);
    chk("R9 ready on pop", {15'h0, r_rdy}, 16'h1);
    chk("R9 popped byte", r_data, 16'h003C);
    m[11] = 16'h003C;
    rx_valid = 1'b0; rx_data = 8'h77;
    acc(1'b0, 6'h2C, 2'd1, 16'h0);
    chk("R9 empty keeps byte", r_data, 16'h003C);
    rx_valid = 1'b1;
    acc(1'b1, 6'h2C, 2'd1, 16'hBEEF);
    chk("R9 no pop on write", {15'h0, r_rdy}, 16'h0);
    rx_valid = 1'b0;
    rd_chk(11, "R9 write ignored");

    for (int a = 0; a < 64; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic ee;
        ee = (sz != 1) || (a[1:0] != 2'b00) || (a > 44);
        acc(1'b0, 6'(a), 2'(sz), 16'h0);
        chk(sz != 1 ? "R3 size error" : "R4 offset error", {15'h0, r_err}, {15'h0, ee});
        chk("R4 read data", r_data, ee ? 16'h0 : expect_of(a / 4));
      end
    end
    acc(1'b1, 6'h30, 2'd1, 16'hFFFF);  chk("R4 write unmapped", {15'h0, r_err}, 16'h1);
    acc(1'b1, 6'h02, 2'd1, 16'hFFFF);  chk("R4 write misaligned", {15'h0, r_err}, 16'h1);
    acc(1'b1, 6'h00, 2'd2, 16'hFFFF);  chk("R3 wide write", {15'h0, r_err}, 16'h1);
    acc(1'b1, 6'h20, 2'd3, 16'hFFFF);  chk("R3 bad size mask", {15'h0, r_err}, 16'h1);
    acc(1'b1, 6'h28, 2'd0, 16'h1234);
    chk("R3 byte write", {15'h0, r_err}, 16'h1);
    chk("R3 no tx strobe", {15'h0, r_txv}, 16'h0);
    rd_all("R4 state unchanged");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule